// File: doc/BRIEF.md
# Prescaled Time-Stamp Base Counter

This block keeps a free-running 16-bit time-stamp value that a conversion engine can sample to mark its results. The counter does not run at the platform clock rate. A programmable prescaler divides the clock and produces a one-cycle tick at the divided rate, and the counter advances by one on each tick. A 4-bit code selects the divide factor from a fixed, uneven table. That table mixes powers of two with factors of 6, 10 and 12, and it also has codes that stop the counter.

The code lives in one 16-bit configuration word. Two independent configuration ports can reach that word, and both map to the same storage. Each port has its own write strobe, address and data, and its own read address and read data. Software should never write from both ports in the same cycle. If it does, port 0 takes effect and a sticky collision flag goes high. Only a reset clears that flag.

Top module: `stamp_timebase`

## Requirements
- R1: After reset the stored code is 0, the stamp is 0x0000, tick is low and collision is low.
- R2: The configuration word is at address 0x02. Its bits [3:0] hold the prescaler code. Bits [15:4] always read as zero, and any data written to them is ignored. A write to any other address changes nothing, and a read from any other address returns 0x0000.
- R3: A write through either port updates the same single word. A read from either port returns that word.
- R4: Code 0 disables the prescaler. Codes 13, 14 and 15 also disable it. While disabled, tick stays low and the stamp holds its value.
- R5: Codes 1 through 12 select divide factors 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256, in that order.
- R6: With factor N, tick is high for exactly one clock cycle in every N. With factor 1, tick is high in every cycle.
- R7: The stamp increments by one at each clock edge where tick is high, and holds otherwise. It wraps from 0xFFFF to 0x0000 without stalling.
- R8: Any write to the configuration word restarts the divide count from zero, even if the code is unchanged. The first tick then comes N-1 cycles after the write edge. The stamp is not cleared by the write.
- R9: If both ports write address 0x02 in the same cycle, port 0's data is stored and collision goes high. Collision stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Platform clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg0_wr | input | 1 | Port 0 write strobe |
| cfg0_addr | input | 8 | Port 0 write address |
| cfg0_wdata | input | 16 | Port 0 write data |
| cfg0_raddr | input | 8 | Port 0 read address |
| cfg0_rdata | output | 16 | Port 0 read data |
| cfg1_wr | input | 1 | Port 1 write strobe |
| cfg1_addr | input | 8 | Port 1 write address |
| cfg1_wdata | input | 16 | Port 1 write data |
| cfg1_raddr | input | 8 | Port 1 read address |
| cfg1_rdata | output | 16 | Port 1 read data |
| tick | output | 1 | One-cycle prescaler pulse |
| stamp | output | 16 | Current time-stamp value |
| collision | output | 1 | Sticky flag for a same-cycle write from both ports |

## Verification
The assertions assume that the write strobes and addresses are always known values. The collision checks assume that only a real same-cycle double write sets the flag. The disable and every-cycle-tick checks read the stored code directly, so they make no assumption about the write data.

The random stimulus writes from one port at a time and sometimes points a write at a wrong address. It drives random upper data bits, so reserved-bit handling is exercised on every write. The only double write is a single directed case, which then checks that the flag stays high and that reset clears it.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    localparam int DATA_W     = 16;
    localparam int CODE_W     = 4;
    localparam int NUM_PORTS  = 2;
    localparam int MAX_FACTOR = 256;
    localparam int CNT_W      = $clog2(MAX_FACTOR);

    typedef logic [CODE_W-1:0] ps_code_t;
    typedef logic [CNT_W-1:0]  div_cnt_t;

    // decoded prescaler selection: enable and terminal count (factor - 1)
    typedef struct packed {
        logic     en;
        div_cnt_t last;
    } div_sel_t;

    // one port's request toward the shared configuration word
    typedef struct packed {
        logic     hit;
        ps_code_t code;
    } cfg_req_t;

    function automatic div_sel_t decode_code(input ps_code_t c);
        div_sel_t s;
        int f;
        case (c)
            4'd1:    f = 1;
            4'd2:    f = 2;
            4'd3:    f = 4;
            4'd4:    f = 6;
            4'd5:    f = 8;
            4'd6:    f = 10;
            4'd7:    f = 12;
            4'd8:    f = 16;
            4'd9:    f = 32;
            4'd10:   f = 64;
            4'd11:   f = 128;
            4'd12:   f = 256;
            default: f = 0;   // R4: 0 and 13..15 stop the prescaler
        endcase
        s.en   = (f != 0);
        s.last = (f == 0) ? '0 : div_cnt_t'(f - 1);
        return s;
    endfunction
endpackage

// File: rtl/tsb_cfg_reg.sv
module tsb_cfg_reg
    import tsb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  cfg_req_t [NUM_PORTS-1:0] req,
    output ps_code_t                 code,
    output logic                     restart,
    output logic                     collision
);
    logic [NUM_PORTS-1:0] hits;
    ps_code_t             code_nxt;
    ps_code_t             code_q;
    logic                 coll_q;

    always_comb begin
        code_nxt = code_q;
        // lowest index written last so port 0 wins (R9)
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            hits[i] = req[i].hit;
            if (req[i].hit) code_nxt = req[i].code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            coll_q <= 1'b0;
        end else begin
            code_q <= code_nxt;
            if ($countones(hits) > 1) coll_q <= 1'b1;
        end
    end

    assign code      = code_q;
    assign restart   = |hits;
    assign collision = coll_q;
endmodule

// File: rtl/tsb_prescaler.sv
module tsb_prescaler
    import tsb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ps_code_t code,
    input  logic     restart,
    output logic     tick
);
    div_sel_t sel;
    div_cnt_t cnt_q;

    assign sel  = decode_code(code);
    assign tick = sel.en && (cnt_q == sel.last);

    always_ff @(posedge clk) begin
        if (rst || restart || !sel.en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tsb_counter.sv
module tsb_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [WIDTH-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (adv) value <= value + 1'b1;
    end
endmodule

// File: rtl/stamp_timebase.sv
module stamp_timebase
    import tsb_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h02,
    parameter int               STAMP_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg0_wr,
    input  logic [ADDR_W-1:0]  cfg0_addr,
    input  logic [DATA_W-1:0]  cfg0_wdata,
    input  logic [ADDR_W-1:0]  cfg0_raddr,
    output logic [DATA_W-1:0]  cfg0_rdata,
    input  logic               cfg1_wr,
    input  logic [ADDR_W-1:0]  cfg1_addr,
    input  logic [DATA_W-1:0]  cfg1_wdata,
    input  logic [ADDR_W-1:0]  cfg1_raddr,
    output logic [DATA_W-1:0]  cfg1_rdata,
    output logic               tick,
    output logic [STAMP_W-1:0] stamp,
    output logic               collision
);
    localparam int RSVD_W = DATA_W - CODE_W;

    logic [NUM_PORTS-1:0] wr_v;
    logic [ADDR_W-1:0]    waddr_v [NUM_PORTS];
    logic [DATA_W-1:0]    wdata_v [NUM_PORTS];
    logic [ADDR_W-1:0]    raddr_v [NUM_PORTS];
    logic [DATA_W-1:0]    rdata_v [NUM_PORTS];
    cfg_req_t [NUM_PORTS-1:0] req;
    ps_code_t             cfg_code;
    logic                 restart;
    logic [2*RSVD_W-1:0]  unused_rsvd;

    assign wr_v       = {cfg1_wr, cfg0_wr};
    assign waddr_v[0] = cfg0_addr;
    assign waddr_v[1] = cfg1_addr;
    assign wdata_v[0] = cfg0_wdata;
    assign wdata_v[1] = cfg1_wdata;
    assign raddr_v[0] = cfg0_raddr;
    assign raddr_v[1] = cfg1_raddr;
    assign cfg0_rdata = rdata_v[0];
    assign cfg1_rdata = rdata_v[1];
    // reserved write bits are dropped (R2)
    assign unused_rsvd = {cfg1_wdata[DATA_W-1:CODE_W], cfg0_wdata[DATA_W-1:CODE_W]};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign req[p].hit  = wr_v[p] && (waddr_v[p] == CFG_ADDR);
        assign req[p].code = wdata_v[p][CODE_W-1:0];
        assign rdata_v[p]  = (raddr_v[p] == CFG_ADDR) ? {{RSVD_W{1'b0}}, cfg_code} : '0;
    end

    tsb_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .code      (cfg_code),
        .restart   (restart),
        .collision (collision)
    );

    tsb_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .code    (cfg_code),
        .restart (restart),
        .tick    (tick)
    );

    tsb_counter #(.WIDTH(STAMP_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (tick),
        .value (stamp)
    );
endmodule

// File: rtl/stamp_timebase_chk.sv
module stamp_timebase_chk (
    input logic        clk,
    input logic        rst,
    input logic        hit0,
    input logic        hit1,
    input logic [3:0]  code,
    input logic [15:0] rdata0,
    input logic        tick,
    input logic [15:0] stamp,
    input logic        collision
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) rdata0[15:4] == 12'h000);
    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (code == 4'd0 || code > 4'd12) |-> !tick);
    // R6
    fast_tick_chk: assert property (@(posedge clk) disable iff (rst) (code == 4'd1) |-> tick);
    // R7
    stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> stamp == 16'($past(stamp) + 16'd1));
    // R7
    stamp_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(stamp));
    // R9
    collide_set_chk: assert property (@(posedge clk) disable iff (rst) (hit0 && hit1) |=> collision);
    // R9
    collide_keep_chk: assert property (@(posedge clk) disable iff (rst) collision |=> collision);
endmodule

bind stamp_timebase stamp_timebase_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hit0      (cfg0_wr && cfg0_addr == 8'h02),
    .hit1      (cfg1_wr && cfg1_addr == 8'h02),
    .code      (cfg_code),
    .rdata0    (cfg0_rdata),
    .tick      (tick),
    .stamp     (stamp),
    .collision (collision)
);

// File: tb/tb_stamp_timebase.sv
module tb_stamp_timebase;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c0_wr = 1'b0, c1_wr = 1'b0;
    logic [7:0]  c0_addr = 8'h02, c1_addr = 8'h02;
    logic [15:0] c0_wd = '0, c1_wd = '0;
    logic [7:0]  c0_ra = 8'h02, c1_ra = 8'h02;
    logic [15:0] c0_rd, c1_rd;
    logic        tick;
    logic [15:0] stamp;
    logic        collision;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [3:0]  m_code = '0;
    int          m_phase = 0;
    logic [15:0] m_stamp = '0;
    logic        m_coll = 1'b0;

    always #4 clk = ~clk;

    stamp_timebase dut (
        .clk(clk), .rst(rst),
        .cfg0_wr(c0_wr), .cfg0_addr(c0_addr), .cfg0_wdata(c0_wd),
        .cfg0_raddr(c0_ra), .cfg0_rdata(c0_rd),
        .cfg1_wr(c1_wr), .cfg1_addr(c1_addr), .cfg1_wdata(c1_wd),
        .cfg1_raddr(c1_ra), .cfg1_rdata(c1_rd),
        .tick(tick), .stamp(stamp), .collision(collision)
    );

    function automatic int exp_factor(input logic [3:0] c);
        case (c)
            4'd1: return 1;    4'd2: return 2;    4'd3: return 4;
            4'd4: return 6;    4'd5: return 8;    4'd6: return 10;
            4'd7: return 12;   4'd8: return 16;   4'd9: return 32;
            4'd10: return 64;  4'd11: return 128; 4'd12: return 256;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_tick();
        int n = exp_factor(m_code);
        return (n != 0) && (m_phase == n - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference model, updated from the values present before each edge
    always @(posedge clk) begin
        logic h0, h1, t;
        h0 = c0_wr && c0_addr == 8'h02;
        h1 = c1_wr && c1_addr == 8'h02;
        t  = exp_tick();
        if (rst) begin
            m_code <= '0; m_phase <= 0; m_stamp <= '0; m_coll <= 1'b0;
        end else begin
            if (t) m_stamp <= m_stamp + 16'd1;
            if (h0 || h1) begin
                m_code  <= h0 ? c0_wd[3:0] : c1_wd[3:0];
                m_phase <= 0;
            end else if (exp_factor(m_code) == 0 || t) begin
                m_phase <= 0;
            end else begin
                m_phase <= m_phase + 1;
            end
            if (h0 && h1) m_coll <= 1'b1;
        end
    end

    // per-cycle comparison against the model (R6, R7, R9)
    always @(negedge clk) begin
        if (!rst) begin
            check(tick == exp_tick(), "R6 tick", tick, exp_tick());
            check(stamp == m_stamp, "R7 stamp", stamp, m_stamp);
            check(collision == m_coll, "R9 collision", collision, m_coll);
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr_port(input int p, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        if (p == 0) begin c0_wr = 1'b1; c0_addr = a; c0_wd = d; end
        else        begin c1_wr = 1'b1; c1_addr = a; c1_wd = d; end
        @(negedge clk);
        c0_wr = 1'b0; c1_wr = 1'b0;
    endtask

    // counts ticks over n sampled cycles, starting at the current negedge
    task automatic count_ticks(input int n, output int t);
        t = 0;
        repeat (n) begin
            if (tick) t++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t;
        logic [15:0] s0;
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        check(stamp == 16'h0 && !tick && !collision, "R1 reset outputs", {stamp, tick, collision}, 0);
        check(c0_rd == 16'h0 && c1_rd == 16'h0, "R1 reset code", c0_rd, 0);

        // R4 code 0 keeps counter frozen
        count_ticks(20, t);
        check(t == 0 && stamp == 16'h0, "R4 code0 frozen", t, 0);

        // R2/R3 write via port 1 with reserved bits set, read from both ports
        wr_port(1, 8'h02, 16'hFFF3);
        check(c0_rd == 16'h0003, "R3 read via port0", c0_rd, 16'h0003);
        check(c1_rd == 16'h0003, "R2 reserved bits zero", c1_rd, 16'h0003);
        c0_ra = 8'h05;
        #1 check(c0_rd == 16'h0, "R2 other address reads zero", c0_rd, 0);
        c0_ra = 8'h02;

        // R2 write to another address ignored
        wr_port(0, 8'h03, 16'h0001);
        check(c0_rd == 16'h0003, "R2 wrong address ignored", c0_rd, 16'h0003);

        // R5 every legal code: two ticks over 2N cycles
        for (int c = 1; c <= 12; c++) begin
            wr_port(c % 2, 8'h02, 16'(c));
            count_ticks(2 * exp_factor(4'(c)), t);
            check(t == 2, $sformatf("R5 code %0d ticks", c), t, 2);
        end

        // R4 codes 13..15 disabled
        for (int c = 13; c <= 15; c++) begin
            wr_port(0, 8'h02, 16'(c));
            s0 = stamp;
            count_ticks(30, t);
            check(t == 0 && stamp == s0, $sformatf("R4 code %0d quiet", c), t, 0);
        end

        // R8 rewrite restarts divide count, stamp kept
        wr_port(0, 8'h02, 16'h0008);
        repeat (10) @(negedge clk);
        s0 = stamp;
        wr_port(1, 8'h02, 16'h0008);
        check(stamp == s0, "R8 stamp kept on write", stamp, s0);
        count_ticks(15, t);
        check(t == 0, "R8 no early tick", t, 0);
        check(tick == 1'b1, "R8 tick at N-1 after write", tick, 1);

        // R9 simultaneous write: port 0 wins, sticky flag
        @(negedge clk);
        c0_wr = 1'b1; c0_addr = 8'h02; c0_wd = 16'h0002;
        c1_wr = 1'b1; c1_addr = 8'h02; c1_wd = 16'h0005;
        @(negedge clk);
        c0_wr = 1'b0; c1_wr = 1'b0;
        check(c1_rd == 16'h0002, "R9 port0 wins", c1_rd, 2);
        check(collision == 1'b1, "R9 flag set", collision, 1);
        repeat (20) @(negedge clk);
        check(collision == 1'b1, "R9 flag sticky", collision, 1);
        do_reset();
        check(collision == 1'b0 && c0_rd == 16'h0, "R9 reset clears flag", collision, 0);

        // R7 wrap at factor 1
        wr_port(0, 8'h02, 16'h0001);
        t = 0;
        while (stamp != 16'hFFFF && t < 70000) begin @(negedge clk); t++; end
        check(stamp == 16'hFFFF, "R7 reached max", stamp, 16'hFFFF);
        @(negedge clk);
        check(stamp == 16'h0000, "R7 wrap to zero", stamp, 0);

        // random single-port traffic checked by the per-cycle model
        repeat (3000) begin
            @(negedge clk);
            c0_wr = 1'b0; c1_wr = 1'b0;
            case ($urandom % 12)
                0: begin
                    c0_wr = 1'b1;
                    c0_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'h02;
                    c0_wd = 16'($urandom);
                end
                1: begin
                    c1_wr = 1'b1;
                    c1_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'h02;
                    c1_wd = 16'($urandom);
                end
                default: ;
            endcase
        end
        @(negedge clk);
        c0_wr = 1'b0; c1_wr = 1'b0;
        check(c0_rd == {12'h0, m_code} && c1_rd == {12'h0, m_code}, "R3 final code", c0_rd, m_code);
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule